// File: doc/BRIEF.md
# Valley-Switching Turn-On Timer

This block chooses the moment each switching cycle of a quasi-resonant flyback converter begins. Every time the gate drive turns off, it starts a blanking interval whose length is set by an 8-bit load code. Heavy load gets the shortest interval, light load the longest, and the range in between gets a blanking frequency that is interpolated linearly. Once the interval has elapsed, the first resonant-valley strobe from an external zero-crossing comparator is accepted. That turn-on is then pushed back by a small extra delay that sweeps slowly up and down, which spreads the switching spectrum. A one-cycle turn-on request follows.

Two guards surround this. If no valley is accepted, a period watchdog starts a cycle anyway, so the switching rate never drops below a floor frequency. An on-time guard raises a forced turn-off when the gate has stayed on too long. An enable input suppresses every turn-on request. Blanking bookkeeping still follows the gate while the enable is low.

All time constants are parameters given in hertz or nanoseconds and converted to clock cycles at elaboration.

Top module: `vsw_turnon_ctl`

## Requirements
- R1: A gate fall is the clock edge at which `gate_on` is sampled low after being sampled high at the previous edge. When `load_code` at that edge is at or above `HI_BP`, the blanking length is L = CLK_HZ / F_MAX_HZ cycles (integer division). A valley strobe sampled at the L-th edge after the fall edge, or at any later edge, is accepted.
- R2: When `load_code` at the fall edge is at or below `LO_BP`, the blanking length is L = CLK_HZ / F_MIN_HZ cycles.
- R3: For codes strictly between the breakpoints, f = F_MIN_HZ + (F_MAX_HZ − F_MIN_HZ)·(code − LO_BP)/(HI_BP − LO_BP), truncated, and L = CLK_HZ / f.
- R4: Strobes sampled before the blanking length has elapsed are ignored. Only the first accepted strobe after a fall starts a turn-on. Every new gate fall restarts the blanking count, including a fall that arrives in the middle of a blanking interval and a fall that arrives while `en` is low.
- R5: Let a strobe be accepted at edge number n after reset, where the first edge is n = 1. Let m = (n−1)/DWELL and r = m mod 2·STEPS. The added delay is D = r when r ≤ STEPS, else 2·STEPS − r. `ton_req` rises D edges later than it would with no delay. STEPS = round(SWEEP_SPAN_NS / clock period) and DWELL = SWEEP_PERIOD_NS / clock period / (2·STEPS).
- R6: With `en` high, a turn-on is issued at the edge where FLOOR = CLK_HZ / F_FLOOR_HZ edges have passed since the last issued turn-on (or since reset). If that edge is itself a gate fall, the turn-on moves to the next edge.
- R7: `toff_force` is high after every edge at which `gate_on` has been sampled high on ON_MAX = ON_MAX_NS / clock period or more consecutive edges. It is low otherwise.
- R8: While `en` is sampled low, no turn-on is issued. A pending sweep delay that expires with `en` low is dropped.
- R9: `ton_req` is registered and never high on two consecutive cycles. Both outputs are low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows turn-on requests when high |
| load_code | input | LW | Load level, higher means heavier load |
| valley_stb | input | 1 | Resonant-valley strobe from the zero-crossing comparator |
| gate_on | input | 1 | Current gate drive state, high while on |
| ton_req | output | 1 | One-cycle turn-on request |
| toff_force | output | 1 | Forced turn-off for excessive on-time |

## Verification
`ton_req` is registered: it rises just after the deciding edge. That edge is the L-th edge after the fall edge when the strobe is accepted with no sweep delay, D edges after acceptance when a delay applies, and the FLOOR-th edge after the previous request when the watchdog fires. `toff_force` rises just after the ON_MAX-th consecutive high sample of the gate and clears one edge after the gate is sampled low. The bench drives inputs on falling edges and runs a behavioural model on the same rising edges as the design. It compares both outputs at the next falling edge, so every result is checked in exactly the cycle it is due. The model uses scaled parameters so that long blanks, sweep turnarounds and watchdog expiries all occur within a short run.

// File: rtl/vsw_turnon_ctl.sv
module vsw_turnon_ctl #(
  parameter int LW              = 8,
  parameter int CLK_HZ          = 250_000_000,
  parameter int F_MAX_HZ        = 130_000,
  parameter int F_MIN_HZ        = 18_500,
  parameter int F_FLOOR_HZ      = 17_000,
  parameter int HI_BP           = 192,
  parameter int LO_BP           = 64,
  parameter int ON_MAX_NS       = 22_000,
  parameter int SWEEP_SPAN_NS   = 265,
  parameter int SWEEP_PERIOD_NS = 2_500_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] load_code,
  input  logic          valley_stb,
  input  logic          gate_on,
  output logic          ton_req,
  output logic          toff_force
);
  localparam int CLK_NS     = 1_000_000_000 / CLK_HZ;
  localparam int FLOOR_CYC  = CLK_HZ / F_FLOOR_HZ;
  localparam int ON_MAX_CYC = ON_MAX_NS / CLK_NS;
  localparam int STEPS      = (SWEEP_SPAN_NS + CLK_NS / 2) / CLK_NS;
  localparam int DWELL_RAW  = (STEPS == 0) ? 1 : SWEEP_PERIOD_NS / CLK_NS / (2 * STEPS);
  localparam int DWELL      = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
  localparam int CW         = $clog2(FLOOR_CYC + 2);
  localparam int OW         = $clog2(ON_MAX_CYC + 2);
  localparam int SW         = $clog2(STEPS + 2);
  localparam int KW         = $clog2(DWELL + 1);
  localparam int NCODE      = 1 << LW;

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_DELAY} st_t;

  function automatic int blank_len(input int code);
    longint f;
    if (code >= HI_BP)      f = F_MAX_HZ;
    else if (code <= LO_BP) f = F_MIN_HZ;
    else f = longint'(F_MIN_HZ)
           + (longint'(F_MAX_HZ - F_MIN_HZ) * longint'(code - LO_BP)) / longint'(HI_BP - LO_BP);
    return int'(longint'(CLK_HZ) / f);
  endfunction

  logic [CW-1:0] blank_rom [NCODE];
  for (genvar c = 0; c < NCODE; c++) begin : g_rom
    localparam int BL = blank_len(c);
    assign blank_rom[c] = CW'(BL);
  end

  logic [SW-1:0] sweep;
  if (STEPS == 0) begin : g_nosweep
    assign sweep = '0;
  end else begin : g_sweep
    logic [KW-1:0] dwell_q;
    logic [SW-1:0] pos_q;
    logic          up_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dwell_q <= '0;
        pos_q   <= '0;
        up_q    <= 1'b1;
      end else if (dwell_q == KW'(DWELL - 1)) begin
        dwell_q <= '0;
        if (up_q) begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == SW'(STEPS - 1)) up_q <= 1'b0;
        end else begin
          pos_q <= pos_q - 1'b1;
          if (pos_q == SW'(1)) up_q <= 1'b1;
        end
      end else begin
        dwell_q <= dwell_q + 1'b1;
      end
    end
    assign sweep = pos_q;
  end

  logic          gate_q;
  st_t           st_q, st_d;
  logic [CW-1:0] bcnt_q, blen_q, pc_q;
  logic [SW-1:0] dcnt_q, dcnt_d;
  logic [OW-1:0] on_q;
  logic          fire;

  wire           fall       = gate_q & ~gate_on;
  wire           blank_done = bcnt_q >= blen_q;
  wire           timeout    = en & ~fall & (pc_q >= CW'(FLOOR_CYC - 1));
  wire [OW-1:0]  on_nx      = (&on_q) ? on_q : on_q + 1'b1;

  always_comb begin
    fire   = 1'b0;
    st_d   = st_q;
    dcnt_d = dcnt_q;
    if (fall) begin
      st_d = S_HUNT;
    end else begin
      case (st_q)
        S_HUNT:
          if (en && valley_stb && blank_done) begin
            if (sweep == '0) begin
              fire = 1'b1;
              st_d = S_IDLE;
            end else begin
              st_d   = S_DELAY;
              dcnt_d = sweep;
            end
          end
        S_DELAY:
          if (dcnt_q == SW'(1)) begin
            fire = en;
            st_d = S_IDLE;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        default: ;
      endcase
    end
    if (timeout) begin
      fire = 1'b1;
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      st_q       <= S_IDLE;
      bcnt_q     <= '0;
      blen_q     <= '0;
      pc_q       <= '0;
      dcnt_q     <= '0;
      on_q       <= '0;
      ton_req    <= 1'b0;
      toff_force <= 1'b0;
    end else begin
      gate_q  <= gate_on;
      st_q    <= st_d;
      dcnt_q  <= dcnt_d;
      ton_req <= fire;
      if (fall) begin
        bcnt_q <= CW'(1);
        blen_q <= blank_rom[load_code];
      end else if (!(&bcnt_q)) begin
        bcnt_q <= bcnt_q + 1'b1;
      end
      if (fire)          pc_q <= '0;
      else if (!(&pc_q)) pc_q <= pc_q + 1'b1;
      on_q       <= gate_on ? on_nx : '0;
      toff_force <= gate_on && (on_nx >= OW'(ON_MAX_CYC));
    end
  end
endmodule

// File: rtl/vsw_turnon_chk.sv
module vsw_turnon_chk #(
  parameter int FLOOR_CYC = 14705
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic gate_on,
  input logic ton_req,
  input logic toff_force
);
  localparam int GW = $clog2(FLOOR_CYC + 2) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= '0;
    else if (ton_req || !en)           gap_q <= '0;
    else if (gap_q <= GW'(FLOOR_CYC))  gap_q <= gap_q + 1'b1;
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |=> !ton_req);

  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ton_req);

  p_toff_after_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(toff_force) |-> $past(gate_on));

  p_toff_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> !toff_force);

  p_floor_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GW'(FLOOR_CYC));
endmodule

bind vsw_turnon_ctl vsw_turnon_chk #(.FLOOR_CYC(FLOOR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate_on(gate_on),
  .ton_req(ton_req), .toff_force(toff_force)
);

// File: tb/vsw_turnon_ctl_tb_top.sv
`timescale 1ns/1ps
module vsw_turnon_ctl_tb_top;
  localparam int CLK_HZ   = 250_000_000;
  localparam int FMAX     = 12_500_000;
  localparam int FMIN     = 2_500_000;
  localparam int FFLOOR   = 1_600_000;
  localparam int HI       = 192;
  localparam int LO       = 64;
  localparam int ONMAX_NS = 240;
  localparam int SPAN_NS  = 20;
  localparam int SPER_NS  = 280;
  localparam int PER_NS   = 4;
  localparam int FLOOR    = CLK_HZ / FFLOOR;
  localparam int ON_MAX   = ONMAX_NS / PER_NS;
  localparam int STEPS    = (SPAN_NS + PER_NS / 2) / PER_NS;
  localparam int DWELL    = SPER_NS / PER_NS / (2 * STEPS);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, valley_stb = 1'b0, gate_on = 1'b0;
  logic [7:0] load_code = '0;
  logic ton_req, toff_force;

  always #2 clk = ~clk;

  vsw_turnon_ctl #(
    .LW(8), .CLK_HZ(CLK_HZ), .F_MAX_HZ(FMAX), .F_MIN_HZ(FMIN), .F_FLOOR_HZ(FFLOOR),
    .HI_BP(HI), .LO_BP(LO), .ON_MAX_NS(ONMAX_NS), .SWEEP_SPAN_NS(SPAN_NS),
    .SWEEP_PERIOD_NS(SPER_NS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .load_code(load_code), .valley_stb(valley_stb),
    .gate_on(gate_on), .ton_req(ton_req), .toff_force(toff_force)
  );

  int checks = 0, failures = 0;

  function automatic int exp_blank(int code);
    longint f;
    if (code >= HI)      f = FMAX;
    else if (code <= LO) f = FMIN;
    else f = longint'(FMIN) + (longint'(FMAX - FMIN) * (code - LO)) / (HI - LO);
    return int'(longint'(CLK_HZ) / f);
  endfunction

  function automatic int exp_sweep(int n);
    int m = (n - 1) / DWELL;
    int r = m % (2 * STEPS);
    return (r <= STEPS) ? r : 2 * STEPS - r;
  endfunction

  // reference model
  int n_edge, mst, mb, mblen, md, mpc, mon, delayed_hits;
  bit mgq, mton, mtoff;
  string mtag = "R9", mregion = "R1";
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edge = 0; mst = 0; mb = 0; mblen = 0; md = 0; mpc = 0; mon = 0;
      mgq = 0; mton = 0; mtoff = 0;
    end else begin
      bit fall, fire;
      int d;
      n_edge++;
      fall = mgq && !gate_on;
      fire = 0;
      d = exp_sweep(n_edge);
      if (fall) begin
        mst = 1; mb = 1; mblen = exp_blank(load_code);
        mregion = (load_code >= HI) ? "R1" : (load_code <= LO) ? "R2" : "R3";
      end else begin
        if (mst == 1) begin
          if (en && valley_stb && mb >= mblen) begin
            if (d == 0) begin fire = 1; mst = 0; mtag = mregion; end
            else begin mst = 2; md = d; end
          end
          mb++;
        end else if (mst == 2) begin
          if (md == 1) begin
            if (en) begin fire = 1; mtag = "R5"; delayed_hits++; end
            mst = 0;
          end else md--;
        end
      end
      if (!fall && en && mpc >= FLOOR - 1) begin
        if (!fire) mtag = "R6";
        fire = 1; mst = 0;
      end
      mpc = fire ? 0 : mpc + 1;
      mgq = gate_on;
      mon = gate_on ? mon + 1 : 0;
      mtoff = gate_on && (mon >= ON_MAX);
      mton = fire;
    end
  end

  // stimulus driver and per-cycle comparison
  bit auto_gate = 0, man_gate = 0, valley_on = 0;
  int vp = 5, on_len = 10, on_left = 0, cyc = 0, pulses = 0, toff_seen = 0;
  bit auto_val = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (ton_req !== mton) begin
        failures++;
        $display("FAIL %s ton_req actual=%0b expected=%0b at %0t",
                 mton ? mtag : (!en ? "R8" : "R4"), ton_req, mton, $time);
      end
      checks++;
      if (toff_force !== mtoff) begin
        failures++;
        $display("FAIL R7 toff_force actual=%0b expected=%0b at %0t", toff_force, mtoff, $time);
      end
      if (ton_req) pulses++;
      if (toff_force) toff_seen++;
    end
    if (on_left > 0) begin
      on_left--;
      if (on_left == 0) auto_val = 0;
    end else if (ton_req && !auto_val) begin
      auto_val = 1; on_left = on_len;
    end
    gate_on    = auto_gate ? auto_val : man_gate;
    valley_stb = valley_on && !gate_on && (cyc % vp == 0);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp_v, bit ok);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  initial begin
    #(PER_NS * 200_000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    run(3);
    check("R9 reset ton_req", ton_req, 0, ton_req === 1'b0);
    check("R9 reset toff_force", toff_force, 0, toff_force === 1'b0);
    rst_n = 1;
    en = 1; auto_gate = 1; valley_on = 1; vp = 5;
    load_code = 220; run(700);
    load_code = 20;  run(900);
    load_code = 128; run(600);
    load_code = 100; run(600);
    load_code = 160; run(600);
    load_code = 64;  run(500);
    load_code = 192; run(500);
    vp = 1; load_code = 220; run(400);
    vp = 3; load_code = 150; run(500);
    // no valleys: watchdog start
    valley_on = 0; p0 = pulses; run(700);
    check("R6 watchdog pulses", pulses - p0, 4, (pulses - p0) >= 3);
    // disabled with gate activity
    run(40); en = 0; auto_gate = 0; man_gate = 0; valley_on = 1; vp = 2;
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      man_gate = 1; run(5); man_gate = 0; run(40);
    end
    check("R8 pulses while disabled", pulses - p0, 0, pulses == p0);
    // fall in the middle of a blanking interval
    en = 1; load_code = 20;
    man_gate = 1; run(5); man_gate = 0; run(50);
    man_gate = 1; run(4); man_gate = 0; run(300);
    // long on-time
    p0 = toff_seen;
    man_gate = 1; run(90); man_gate = 0; run(5);
    check("R7 forced turn-off seen", toff_seen - p0, 30, (toff_seen - p0) > 20);
    check("R7 forced turn-off cleared", toff_force, 0, toff_force === 1'b0);
    auto_gate = 1; valley_on = 1; vp = 4; load_code = 200; run(600);
    check("R5 delayed turn-ons exercised", delayed_hits, 1, delayed_hits > 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule